// File: doc/BRIEF.md
# Clocked Multi-Input Step Neuron

This block is a single artificial neuron for a small fixed-point neural network. It takes N unsigned inputs and N unsigned weights, each RES+1 bits wide. The inputs arrive on one flat packed bus and the weights on another. Each input is multiplied by the weight at the same index, and each product is rescaled on its own by a right shift of RES+1 bits. The scaled terms are then summed in an accumulator wide enough that it cannot overflow. A step activation compares the sum against a threshold parameter, and the result is held in an output register.

Operands enter through a valid/ready handshake and the result leaves through a second valid/ready handshake. The block holds exactly one result. An operand set is accepted on a rising edge where both in_valid and in_ready are high, and its result appears at the output on that same edge. A result stays on out_data, with out_valid high, until the consumer takes it with out_ready. While a result waits and out_ready is low, in_ready is low and no new operand set is taken. When the consumer drains the held result in a cycle where a new operand set is offered, both happen on the same edge, so a stream can advance one result per cycle.

Top module: `step_neuron`

## Requirements
- R1: Operand k (k = 0..N-1) sits in bits [k*(RES+1) +: RES+1] of in_data, and weight k sits in the same bits of in_weight, so element 0 occupies the least significant field. Each input is multiplied only with the weight of the same index.
- R2: Each product is shifted right by RES+1 bits and truncated on its own, before it is added to the sum. The sum is not shifted after accumulation.
- R3: The accumulator is RES+1+ceil(log2(N)) bits wide, so a sum of N scaled terms never wraps. For example, two terms of 2^(RES+1)/2 each give a sum of 2^(RES+1), not 0.
- R4: The output value is the full-scale value 2^(RES+1)-1 when the sum is greater than or equal to THRESH, and 0 otherwise. A sum equal to THRESH gives full scale. THRESH must be below 2^(accumulator width).
- R5: An operand set accepted on a rising edge (in_valid and in_ready both high) sets out_valid and puts its result on out_data on that same edge. The result is visible in the cycle after the operands were sampled.
- R6: While out_valid is high and out_ready is low, out_data and out_valid hold, in_ready is low, and offered operands are not taken.
- R7: in_ready is high whenever out_valid is low or out_ready is high. When a result is drained and new operands are offered in the same cycle, the next result replaces it on that edge with out_valid staying high.
- R8: A synchronous active-high reset clears out_valid and out_data to 0.
- R9: An edge with in_valid low leaves out_data unchanged. If out_ready is high on that edge, out_valid falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the block acts on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand set on in_data and in_weight is valid |
| in_ready | output | 1 | Block can take an operand set this cycle |
| in_data | input | N*(RES+1) | Packed inputs, element 0 in the least significant field |
| in_weight | input | N*(RES+1) | Packed weights, element 0 in the least significant field |
| out_valid | output | 1 | out_data holds a result not yet taken |
| out_ready | input | 1 | Consumer takes the held result this cycle |
| out_data | output | RES+1 | Step activation result: 0 or 2^(RES+1)-1 |

## Verification
Two events can fall on the same edge: the consumer drains the held result, and a new operand set is accepted. The bench provokes this by holding out_ready and in_valid high over consecutive cycles, with operand sets that alternate between a sum above the threshold and a sum below it. The bench judges the case correct when out_valid never drops and out_data changes to each new expected value one edge after its operands are presented. Stalled cases, with out_ready held low, check that this overlap does not occur.

// File: rtl/neuron_pkg.sv
package neuron_pkg;
  // Width of an accumulator that holds the sum of n terms, each w bits wide.
  function automatic int acc_width(input int w, input int n);
    return w + $clog2(n);
  endfunction
endpackage

// File: rtl/neuron_term.sv
module neuron_term #(
  parameter int W = 17
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] scaled
);
  localparam int PW = 2 * W;
  logic [PW-1:0] prod;

  always_comb begin
    prod   = PW'(a) * PW'(b);
    scaled = prod[PW-1:W];  // R2: per-term right shift by W = RES+1
  end

  // R2: (2^W-1)^2 >> W peaks at 2^W-2, so a scaled term is never all ones
  always_comb begin
    a_r2_term_bound: assert (scaled != {W{1'b1}} || $isunknown(prod));
  end
endmodule

// File: rtl/neuron_adder.sv
module neuron_adder #(
  parameter int W  = 17,
  parameter int N  = 4,
  parameter int SW = W + $clog2(N)
) (
  input  logic [N*W-1:0] terms,
  output logic [SW-1:0]  sum
);
  always_comb begin
    sum = '0;
    for (int i = 0; i < N; i++) begin
      sum = sum + SW'(terms[i*W +: W]);  // R3: widened before adding
    end
  end
endmodule

// File: rtl/neuron_step.sv
module neuron_step #(
  parameter int W  = 17,
  parameter int SW = 19,
  parameter logic [SW-1:0] THR = '0
) (
  input  logic [SW-1:0] sum,
  output logic [W-1:0]  act
);
  // R4: full scale at or above the threshold, zero below it
  assign act = (sum >= THR) ? {W{1'b1}} : '0;
endmodule

// File: rtl/step_neuron.sv
module step_neuron
  import neuron_pkg::*;
#(
  parameter int          RES    = 16,
  parameter int          N      = 4,
  parameter int unsigned THRESH = 32'd65536
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [N*(RES+1)-1:0] in_data,
  input  logic [N*(RES+1)-1:0] in_weight,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [RES:0]         out_data
);
  localparam int W  = RES + 1;
  localparam int SW = acc_width(W, N);
  localparam logic [SW-1:0] THR = SW'(THRESH);

  logic [N*W-1:0] terms;
  logic [SW-1:0]  sum;
  logic [W-1:0]   act;
  logic           accept;

  // R1: unpack fields, element 0 in the least significant slot
  for (genvar k = 0; k < N; k++) begin : g_term
    neuron_term #(.W(W)) u_term (
      .a      (in_data[k*W +: W]),
      .b      (in_weight[k*W +: W]),
      .scaled (terms[k*W +: W])
    );
  end

  neuron_adder #(.W(W), .N(N), .SW(SW)) u_adder (
    .terms (terms),
    .sum   (sum)
  );

  neuron_step #(.W(W), .SW(SW), .THR(THR)) u_step (
    .sum (sum),
    .act (act)
  );

  // R7: room for a new set when empty or when the held result leaves now
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin                         // R8
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin             // R5
      out_valid <= 1'b1;
      out_data  <= act;
    end else if (out_ready) begin          // R9
      out_valid <= 1'b0;
    end
  end

  // R6: a stalled result is held and no operands enter
  a_r6_hold_stall: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  a_r6_block_input: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);
  // R5: an accepted set yields a valid result on the next cycle
  a_r5_accept_valid: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);
  // R4: the output is only ever one of the two step levels
  a_r4_two_levels: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data == '0 || out_data == {W{1'b1}}));
  // R8: the cycle after reset starts empty
  a_r8_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid && out_data == '0);
  // R9: with no input, data never changes
  a_r9_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));
endmodule

// File: tb/step_neuron_tb.sv
module step_neuron_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RES = 16;
  localparam int N   = 4;
  localparam int W   = RES + 1;
  localparam int unsigned THRESH = 98302;
  localparam logic [W-1:0] FULL = {W{1'b1}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [N*W-1:0] in_data   = '0;
  logic [N*W-1:0] in_weight = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [W-1:0] out_data;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  step_neuron #(.RES(RES), .N(N), .THRESH(THRESH)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_weight(in_weight), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_ops();
    in_data = '0;
    in_weight = '0;
  endtask

  task automatic set_op(input int k, input int a, input int b);
    in_data[k*W +: W]   = W'(a);
    in_weight[k*W +: W] = W'(b);
  endtask

  // drive at falling edge, sample 1 after the next rising edge
  task automatic step_edge();
    @(posedge clk);
    #1;
  endtask

  task automatic present_and_check(input string req, input logic [W-1:0] exp);
    @(negedge clk);
    in_valid = 1'b1;
    out_ready = 1'b1;
    step_edge();
    check(req, {31'd0, out_valid}, 32'd1);
    check(req, 32'(out_data), 32'(exp));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) step_edge();
    check("R8 reset valid", {31'd0, out_valid}, 32'd0);
    check("R8 reset data", 32'(out_data), 32'd0);
    check("R7 ready when empty", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_threshold();
    // 65535 + 32767 = 98302 == THRESH
    clear_ops(); set_op(0, 131070, 65536); set_op(1, 65534, 65536);
    present_and_check("R4 equal threshold", FULL);
    // 65535 + 32766 = 98301 below
    clear_ops(); set_op(0, 131070, 65536); set_op(1, 65532, 65536);
    present_and_check("R4 below threshold", '0);
  endtask

  task automatic t_per_term_shift();
    // three terms of (2^32-1): per-term 3*32767=98301 (<), shift-after 98303
    clear_ops();
    for (int k = 0; k < 3; k++) set_op(k, 65535, 65537);
    present_and_check("R2 per-term truncation", '0);
  endtask

  task automatic t_no_overflow();
    // two terms of 65536 -> 131072, a 17-bit sum would wrap to 0
    clear_ops(); set_op(0, 131071, 65537); set_op(1, 131071, 65537);
    present_and_check("R3 sum beyond 17 bits", FULL);
    clear_ops();
    for (int k = 0; k < N; k++) set_op(k, 131071, 131071);
    present_and_check("R3 all max operands", FULL);
  endtask

  task automatic t_field_order();
    clear_ops(); set_op(3, 131070, 65536); set_op(2, 65534, 65536);
    present_and_check("R1 upper fields", FULL);
    clear_ops();
    in_data[3*W +: W] = W'(131071);
    in_weight[2*W +: W] = W'(131071);
    present_and_check("R1 mismatched index", '0);
  endtask

  task automatic t_latency();
    clear_ops(); set_op(0, 131070, 65536); set_op(1, 65534, 65536);
    @(negedge clk);
    in_valid = 1'b1; out_ready = 1'b1;
    #1;
    check("R5 not before edge", 32'(out_data), 32'd0);
    step_edge();
    check("R5 after one edge", 32'(out_data), 32'(FULL));
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic t_stall();
    // hold a full-scale result, then offer a zero-result set
    clear_ops(); set_op(0, 131070, 65536); set_op(1, 65534, 65536);
    @(negedge clk); in_valid = 1'b1; out_ready = 1'b0;
    step_edge();
    clear_ops();
    @(negedge clk);
    check("R6 ready low on stall", {31'd0, in_ready}, 32'd0);
    repeat (2) step_edge();
    check("R6 valid held", {31'd0, out_valid}, 32'd1);
    check("R6 data held", 32'(out_data), 32'(FULL));
    @(negedge clk); in_valid = 1'b0; out_ready = 1'b1;
    step_edge();
    check("R9 drained, valid falls", {31'd0, out_valid}, 32'd0);
    check("R9 data kept", 32'(out_data), 32'(FULL));
  endtask

  task automatic t_back_to_back();
    @(negedge clk); in_valid = 1'b1; out_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      clear_ops();
      if (i % 2 == 0) begin set_op(0, 131070, 65536); set_op(1, 65534, 65536); end
      step_edge();
      check("R7 valid stays up", {31'd0, out_valid}, 32'd1);
      check("R7 streamed value", 32'(out_data), (i % 2 == 0) ? 32'(FULL) : 32'd0);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic t_mid_reset();
    clear_ops(); set_op(0, 131070, 65536); set_op(1, 65534, 65536);
    @(negedge clk); in_valid = 1'b1; out_ready = 1'b0;
    step_edge();
    @(negedge clk); in_valid = 1'b0; rst = 1'b1;
    step_edge();
    check("R8 mid reset valid", {31'd0, out_valid}, 32'd0);
    check("R8 mid reset data", 32'(out_data), 32'd0);
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_threshold();
    t_per_term_shift();
    t_no_overflow();
    t_field_order();
    t_latency();
    t_stall();
    t_back_to_back();
    t_mid_reset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule